// File: doc/BRIEF.md
# SPI Host Interrupt and Soft-Reset Controller

This unit sits next to an SPI host core and turns its single-cycle event pulses into one level-sensitive interrupt line. Each event source sets a sticky bit in a status register. Software clears a status bit by writing a one to that bit position. A per-source enable register selects which status bits can reach the interrupt. A single global enable bit then gates the combined result before it drives the output.

The same register bus also reaches a soft-reset register. A write to that register takes effect only when the written word equals a fixed key. A key write produces a one-cycle reset pulse for the attached core. The same write returns the status, per-source enable and global enable registers to zero. A write of any other value to the reset register does nothing.

The bus is a simple single-cycle interface. A write happens on any clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and global enable registers read zero, `irq_o` is low and `core_rst_o` is low.
- R2: An event pulse sets its status bit on the next clock edge, whatever the enable settings are. The bit then stays set until it is cleared.
- R3: A write to offset 0x20 clears each status bit whose position holds a one in the written word. Status bits at positions holding a zero are unchanged.
- R4: When an event pulse and a clearing write for the same bit fall in the same cycle, the bit ends up set.
- R5: Offset 0x28 is the per-source enable register. It can be written and read back in bits 6:0, and bits 31:7 read zero.
- R6: Offset 0x1C holds the global enable in bit 31 only. All other bits of that word read zero and ignore writes.
- R7: `irq_o` is high exactly when the global enable is set and at least one source has both its status bit and its enable bit set.
- R8: Writing the word 0x0000000A to offset 0x40 drives `core_rst_o` high for the cycle that follows the write. The same write leaves status, enable and global enable at zero.
- R9: Writing any other value to offset 0x40 leaves `core_rst_o` low and leaves all registers unchanged.
- R10: The bit positions, used in the status and enable registers alike, are: bit 2 transmit FIFO empty, bit 6 transmit FIFO half empty, bit 0 mode fault, bit 4 receive full, bit 3 transmit underrun, bit 1 target-side mode fault, bit 5 receive overrun.
- R11: Reads of unmapped offsets, and of offset 0x40, return zero. Writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | Event pulses, one per source, with positions as in R10 |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt line |
| core_rst_o | output | 1 | One-cycle reset pulse for the attached core |

## Verification
The bench builds the block with its default parameters: seven sources, an 8-bit offset and the key 0x0A. With these values every source position in R10 can be driven, and the full 32-bit key compare and the bit-31 global enable are both exercised. A behavioural model runs alongside the design and is compared on every cycle. The stimulus covers directed cases: a clear that coincides with an event, near-miss key values, and a key write arriving while events are pending. After those, randomized event and write traffic is applied.

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_GIE  = 8'h1C,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_EN   = 8'h28,
  parameter logic [ADDR_W-1:0] OFF_RST  = 8'h40,
  parameter logic [31:0] RST_KEY = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o,
  output logic              core_rst_o
);
  localparam int PAD = 32 - NUM_SRC;

  logic [NUM_SRC-1:0] status, enable, clr;
  logic gie, key_hit;

  assign key_hit = reg_wr && reg_addr == OFF_RST && reg_wdata == RST_KEY;
  assign clr     = (reg_wr && reg_addr == OFF_STAT) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign irq_o   = gie && |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= '0;
      enable     <= '0;
      gie        <= 1'b0;
      core_rst_o <= 1'b0;
    end else if (key_hit) begin
      status     <= '0;
      enable     <= '0;
      gie        <= 1'b0;
      core_rst_o <= 1'b1;
    end else begin
      core_rst_o <= 1'b0;
      status     <= (status & ~clr) | evt_i;
      if (reg_wr && reg_addr == OFF_EN)  enable <= reg_wdata[NUM_SRC-1:0];
      if (reg_wr && reg_addr == OFF_GIE) gie    <= reg_wdata[31];
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_GIE:  reg_rdata = {gie, 31'b0};
      OFF_STAT: reg_rdata = {{PAD{1'b0}}, status};
      OFF_EN:   reg_rdata = {{PAD{1'b0}}, enable};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_RST  = 8'h40,
  parameter logic [31:0] RST_KEY = 32'h0000_000A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_o,
  input logic              core_rst_o,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic              gie
);
  logic key_wr, rst_wr, stat_wr;
  assign key_wr  = reg_wr && reg_addr == OFF_RST && reg_wdata == RST_KEY;
  assign rst_wr  = reg_wr && reg_addr == OFF_RST;
  assign stat_wr = reg_wr && reg_addr == OFF_STAT;

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i && !key_wr) |=> ((status & $past(evt_i)) == $past(evt_i)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && evt_i == '0) |=> ((status & $past(reg_wdata[NUM_SRC-1:0])) == '0));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie && (status & enable) != '0));

  p_key_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (core_rst_o && status == '0 && enable == '0 && !gie));

  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |-> $past(key_wr));

  p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && !key_wr) |=> !core_rst_o);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .OFF_STAT(OFF_STAT),
  .OFF_RST(OFF_RST), .RST_KEY(RST_KEY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_o(irq_o),
  .core_rst_o(core_rst_o), .status(status), .enable(enable), .gie(gie)
);

// File: tb/spi_irq_ctrl_tb_top.sv
module spi_irq_ctrl_tb_top;
  localparam int B_MODEF = 0, B_TMODEF = 1, B_TXE = 2, B_TXUR = 3,
                 B_RXF = 4, B_RXOR = 5, B_TXHE = 6; // R10 positions

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] evt_i = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_o, core_rst_o;

  int n_vec = 0, n_bad = 0;
  int m_stat = 0, m_en = 0, m_gie = 0, m_rst = 0;

  always #2 clk = ~clk;

  spi_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .core_rst_o(core_rst_o)
  );

  function automatic int model_read(input int a);
    case (a)
      'h1C: return m_gie << 31;
      'h20: return m_stat;
      'h28: return m_en;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag, input int raddr);
    reg_wr = 1'b0;
    reg_addr = raddr[7:0];
    #0.5;
    check(tag, int'(reg_rdata), model_read(raddr));
    check("R7 irq", int'(irq_o), (m_gie != 0 && (m_stat & m_en) != 0) ? 1 : 0);
    check("R8 core_rst", int'(core_rst_o), m_rst);
  endtask

  task automatic step(input int evt, input bit wr, input int addr, input int wdata,
                      input int raddr, input string tag);
    int ns, ne, ng, nr;
    @(negedge clk);
    evt_i = evt[6:0]; reg_wr = wr; reg_addr = addr[7:0]; reg_wdata = wdata;
    ns = m_stat; ne = m_en; ng = m_gie; nr = 0;
    if (wr && addr == 'h40 && wdata == 'hA) begin
      ns = 0; ne = 0; ng = 0; nr = 1;
    end else begin
      if (wr && addr == 'h20) ns = ns & ~(wdata & 'h7F);
      ns = ns | (evt & 'h7F);
      if (wr && addr == 'h28) ne = wdata & 'h7F;
      if (wr && addr == 'h1C) ng = (wdata >> 31) & 1;
    end
    @(posedge clk);
    #0.5;
    evt_i = '0;
    m_stat = ns; m_en = ne; m_gie = ng; m_rst = nr;
    compare(tag, raddr);
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    compare("R1 status", 'h20);
    compare("R1 enable", 'h28);
    compare("R1 gie", 'h1C);
    @(negedge clk); rst_n = 1'b1;

    step(1 << B_TXE, 0, 0, 0, 'h20, "R2 latch txe no enable");
    step(0, 0, 0, 0, 'h20, "R2 hold");
    step(1 << B_RXOR | 1 << B_MODEF, 0, 0, 0, 'h20, "R10 positions");
    step(0, 1, 'h28, 'hFFFF_FFFF, 'h28, "R5 enable upper zero");
    step(0, 0, 0, 0, 'h20, "R7 no gie");
    step(0, 1, 'h1C, 'h7FFF_FFFF, 'h1C, "R6 non-31 bits");
    step(0, 1, 'h1C, 'h8000_0000, 'h1C, "R6 gie set");
    step(0, 1, 'h20, 1 << B_TXE, 'h20, "R3 clear one");
    step(1 << B_TXHE, 1, 'h20, 1 << B_TXHE, 'h20, "R4 event wins");
    step(0, 1, 'h20, 'h7F, 'h20, "R3 clear all");
    step(0, 1, 'h28, 1 << B_RXF, 'h28, "R5 enable rxf");
    step(1 << B_TXUR, 0, 0, 0, 'h20, "R7 masked src");
    step(1 << B_RXF, 0, 0, 0, 'h20, "R7 enabled src");
    step(0, 1, 'h30, 'hFFFF_FFFF, 'h30, "R11 unmapped");
    step(0, 0, 0, 0, 'h40, "R11 reset reg reads zero");
    step(0, 1, 'h40, 'h0000_010A, 'h20, "R9 near key");
    step(0, 1, 'h40, 'h0000_000B, 'h28, "R9 wrong key");
    step(1 << B_TMODEF, 1, 'h40, 'h0000_000A, 'h20, "R8 key reset");
    step(0, 0, 0, 0, 'h1C, "R8 pulse ends");
    step(1 << B_TMODEF, 0, 0, 0, 'h20, "R2 after reset");

    for (int i = 0; i < 3000; i++) begin
      int a, sel, wd;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 'h1C; 1: a = 'h20; 2: a = 'h28; 3: a = 'h40; 4: a = 'h24; default: a = 'h20;
      endcase
      wd = (sel == 3 && $urandom_range(0, 3) == 0) ? 'hA : int'($urandom);
      step(($urandom_range(0, 3) == 0) ? int'($urandom) & 'h7F : 0,
           $urandom_range(0, 2) == 0, a, wd,
           ($urandom_range(0, 2) == 0) ? 'h1C : (($urandom_range(0, 1) == 0) ? 'h20 : 'h28),
           "R2 R3 R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule